// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block is a bus-master sequencer that follows a chain of transmit descriptors in host memory. Each descriptor holds a link to the next descriptor, a command/status word and a pointer to one buffer fragment. The walker reads the command word first and continues only when the ownership flag shows that software has handed the descriptor to hardware. It then reads the link and the buffer pointer, asks the MAC transmit path to fetch the fragment (start address and byte length on a request/ack port), writes the command word back with ownership returned, and moves on to the linked descriptor.

A packet may span several descriptors. The "more" flag marks every descriptor except the last. Only the last one receives the MAC's completion status and forwards the suppress-CRC request. A descriptor may ask for an interrupt, which is raised as a one-cycle pulse when its ownership is returned. When the walker meets a descriptor that hardware does not own, it stops and keeps that address, so a later start command polls it again. A link whose low two bits are not zero halts the walker with an error flag. A compatibility input makes the walker take the buffer pointer from the fourth descriptor word.

States: `S_IDLE` (stopped, waiting for start), `S_RD_CMD` (read command word at +0x4), `S_RD_LINK` (read link at +0x0), `S_RD_BUF` (read buffer pointer at +0x8, or +0xC in compatibility mode), `S_FRAG` (fragment request outstanding), `S_WB` (command word write outstanding), `S_NEXT` (step to the linked descriptor), `S_HALT` (stopped on a bad link). Transitions: IDLE/HALT→RD_CMD on `start`; RD_CMD→IDLE on a read with ownership 0; RD_CMD→RD_LINK on a read with ownership 1; RD_LINK→HALT on a misaligned link; RD_LINK→RD_BUF otherwise; RD_BUF→FRAG when the byte count is nonzero, RD_BUF→WB when it is zero; FRAG→WB on `frag_ack`; WB→NEXT on `mwr_ack`; NEXT→RD_CMD always.

Top module: `txdesc_walker`

## Requirements
- R1: After reset `busy`, `err`, `desc_irq`, `mrd_req`, `mwr_req` and `frag_req` are all 0.
- R2: A `start` pulse with `start_from_head`=1 begins at `head_ptr`; with `start_from_head`=0 it begins at the descriptor address where the walker last stopped.
- R3: A descriptor whose command word bit 31 (ownership) is 0 stops the walker (`busy` drops) without any fragment request or write to that descriptor.
- R4: For an owned descriptor with a nonzero byte count (command bits 11:0), one fragment request carries the buffer pointer (any byte alignment) as address and that count as length; a count of 0 produces no fragment request but the descriptor is still written back.
- R5: `frag_last` equals the inverse of command bit 30 (more); a packet spanning descriptors produces `frag_last`=0 for every descriptor but the final one.
- R6: The write-back to offset +0x4 of a non-final descriptor is the fetched command word with bit 31 cleared; for the final descriptor bits 27:16 are also replaced by `mac_status`.
- R7: When command bit 29 is set, `desc_irq` pulses for exactly one cycle after that descriptor's write-back is acknowledged; otherwise it stays 0.
- R8: `frag_nocrc` follows command bit 28 only on the final fragment of a packet and is 0 on any fragment with `frag_last`=0.
- R9: With `compat`=1 the buffer pointer is read from offset +0xC and the word at +0x8 has no effect on the fragment address.
- R10: A link value with bits 1:0 not both zero sets `err`, stops the walker and leaves that descriptor without fragment request or write-back; the next `start` clears `err`.
- R11: Memory read, memory write and fragment requests stay asserted with stable address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start/resume command pulse |
| start_from_head | input | 1 | Load `head_ptr` on start when 1 |
| head_ptr | input | 32 | Address of the first descriptor |
| compat | input | 1 | Buffer pointer at +0xC instead of +0x8 |
| mac_status | input | 12 | Completion status written into final descriptors |
| mrd_req | output | 1 | Memory word read request |
| mrd_addr | output | 32 | Read address |
| mrd_ack | input | 1 | Read acknowledge, data valid |
| mrd_data | input | 32 | Read data |
| mwr_req | output | 1 | Memory word write request |
| mwr_addr | output | 32 | Write address |
| mwr_data | output | 32 | Write data |
| mwr_ack | input | 1 | Write acknowledge |
| frag_req | output | 1 | Fragment fetch request to the MAC path |
| frag_addr | output | 32 | Fragment start byte address |
| frag_len | output | 12 | Fragment byte length |
| frag_last | output | 1 | Fragment ends the packet |
| frag_nocrc | output | 1 | MAC must not append CRC |
| frag_ack | input | 1 | Fragment request accepted |
| desc_irq | output | 1 | Descriptor interrupt pulse |
| busy | output | 1 | Walker is active |
| err | output | 1 | Walker halted on a misaligned link |

## Verification
The hardest situation to reach is a resume after an ownership stop: the walker must come back to the very descriptor it refused, not to the head, and then cross a multi-descriptor packet whose final piece has a zero byte count. The bench builds the list in a behavioural memory, lets the walker park on an unowned descriptor, then hands that descriptor and its successors to hardware in memory and pulses `start` without reloading the head. The chain then runs through into a compatibility-mode descriptor and a misaligned link so that the error halt and its recovery through a fresh head follow from the same continuing walk.

// File: rtl/txdw_pkg.sv
package txdw_pkg;

    localparam int OWN_BIT   = 31;
    localparam int MORE_BIT  = 30;
    localparam int INTR_BIT  = 29;
    localparam int NOCRC_BIT = 28;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CMD,
        S_RD_LINK,
        S_RD_BUF,
        S_FRAG,
        S_WB,
        S_NEXT,
        S_HALT
    } walk_st_t;

    typedef struct packed {
        logic more;
        logic intr;
        logic nocrc;
    } desc_flags_t;

endpackage

// File: rtl/txdw_decode.sv
module txdw_decode
    import txdw_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [31:0]      cmd,
    output desc_flags_t      flags,
    output logic [LEN_W-1:0] len,
    output logic             len_zero
);

    always_comb begin
        flags.more  = cmd[MORE_BIT];
        flags.intr  = cmd[INTR_BIT];
        flags.nocrc = cmd[NOCRC_BIT];
        len         = cmd[LEN_W-1:0];
        len_zero    = (cmd[LEN_W-1:0] == '0);
    end

endmodule

// File: rtl/txdw_wbword.sv
module txdw_wbword
    import txdw_pkg::*;
#(
    parameter int STAT_W   = 12,
    parameter int STAT_LSB = 16
) (
    input  logic [31:0]       cmd,
    input  logic              is_final,
    input  logic [STAT_W-1:0] status,
    output logic [31:0]       word
);

    localparam int STAT_MSB = STAT_LSB + STAT_W - 1;

    always_comb begin
        word          = cmd;
        word[OWN_BIT] = 1'b0;
        if (is_final) begin
            word[STAT_MSB:STAT_LSB] = status;
        end
    end

endmodule

// File: rtl/txdw_irqgen.sv
module txdw_irqgen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R7

endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txdw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LEN_W    = 12,
    parameter int STAT_W   = 12,
    parameter int STAT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_from_head,
    input  logic [AW-1:0]     head_ptr,
    input  logic              compat,
    input  logic [STAT_W-1:0] mac_status,
    output logic              mrd_req,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              mwr_req,
    output logic [AW-1:0]     mwr_addr,
    output logic [31:0]       mwr_data,
    input  logic              mwr_ack,
    output logic              frag_req,
    output logic [AW-1:0]     frag_addr,
    output logic [LEN_W-1:0]  frag_len,
    output logic              frag_last,
    output logic              frag_nocrc,
    input  logic              frag_ack,
    output logic              desc_irq,
    output logic              busy,
    output logic              err
);

    localparam logic [AW-1:0] OFS_LINK   = AW'(32'h0);
    localparam logic [AW-1:0] OFS_CMD    = AW'(32'h4);
    localparam logic [AW-1:0] OFS_BUF    = AW'(32'h8);
    localparam logic [AW-1:0] OFS_BUF_C  = AW'(32'hC);

    walk_st_t          state_q, state_d;
    logic [AW-1:0]     cur_q;
    logic [31:0]       cmd_q;
    logic [AW-1:0]     link_q;
    logic [AW-1:0]     buf_q;
    logic              err_q;

    desc_flags_t       flags;
    logic [LEN_W-1:0]  len;
    logic              len_zero;
    logic [31:0]       wb_word;
    logic              irq_fire;
    logic              stopped;
    logic              link_bad;

    txdw_decode #(.LEN_W(LEN_W)) u_dec (
        .cmd      (cmd_q),
        .flags    (flags),
        .len      (len),
        .len_zero (len_zero)
    );

    txdw_wbword #(.STAT_W(STAT_W), .STAT_LSB(STAT_LSB)) u_wb (
        .cmd      (cmd_q),
        .is_final (!flags.more),
        .status   (mac_status),
        .word     (wb_word)
    );

    txdw_irqgen u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (irq_fire),
        .pulse (desc_irq)
    );

    assign stopped  = (state_q == S_IDLE) || (state_q == S_HALT);
    assign link_bad = (mrd_data[1:0] != 2'b00);
    assign irq_fire = (state_q == S_WB) && mwr_ack && flags.intr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_HALT: begin
                if (start) state_d = S_RD_CMD;
            end
            S_RD_CMD: begin
                if (mrd_ack) state_d = mrd_data[OWN_BIT] ? S_RD_LINK : S_IDLE;
            end
            S_RD_LINK: begin
                if (mrd_ack) state_d = link_bad ? S_HALT : S_RD_BUF;
            end
            S_RD_BUF: begin
                if (mrd_ack) state_d = len_zero ? S_WB : S_FRAG;
            end
            S_FRAG: begin
                if (frag_ack) state_d = S_WB;
            end
            S_WB: begin
                if (mwr_ack) state_d = S_NEXT;
            end
            S_NEXT: begin
                state_d = S_RD_CMD;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // descriptor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            cmd_q  <= '0;
            link_q <= '0;
            buf_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_HALT: begin
                    if (start) begin
                        err_q <= 1'b0;
                        if (start_from_head) cur_q <= head_ptr;
                    end
                end
                S_RD_CMD: begin
                    if (mrd_ack) cmd_q <= mrd_data;
                end
                S_RD_LINK: begin
                    if (mrd_ack) begin
                        link_q <= AW'(mrd_data);
                        if (link_bad) err_q <= 1'b1;
                    end
                end
                S_RD_BUF: begin
                    if (mrd_ack) buf_q <= AW'(mrd_data);
                end
                S_NEXT: begin
                    cur_q <= link_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mrd_req    = 1'b0;
        mrd_addr   = cur_q;
        mwr_req    = 1'b0;
        mwr_addr   = cur_q + OFS_CMD;
        mwr_data   = wb_word;
        frag_req   = 1'b0;
        frag_addr  = buf_q;
        frag_len   = len;
        frag_last  = !flags.more;
        frag_nocrc = flags.nocrc && !flags.more;
        busy       = !stopped;
        err        = err_q;
        unique case (state_q)
            S_RD_CMD: begin
                mrd_req  = 1'b1;
                mrd_addr = cur_q + OFS_CMD;
            end
            S_RD_LINK: begin
                mrd_req  = 1'b1;
                mrd_addr = cur_q + OFS_LINK;
            end
            S_RD_BUF: begin
                mrd_req  = 1'b1;
                mrd_addr = cur_q + (compat ? OFS_BUF_C : OFS_BUF);
            end
            S_FRAG:  frag_req = 1'b1;
            S_WB:    mwr_req  = 1'b1;
            default: ;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy && !err); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr)); // R11

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req && !mwr_ack |=> mwr_req && $stable(mwr_addr) && $stable(mwr_data)); // R11

    AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frag_req && !frag_ack |=> frag_req && $stable(frag_addr) && $stable(frag_len)); // R11

    AST_FRAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frag_req |-> frag_len != '0); // R4

    AST_WB_RETURNS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req |-> !mwr_data[OWN_BIT]); // R6

    AST_NOCRC_FINAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        frag_req && frag_nocrc |-> frag_last); // R8

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mrd_req && !mwr_req && !frag_req); // R10

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mrd_req, mwr_req, frag_req})); // R11

endmodule

// File: tb/sim_txdesc_walker.sv
module sim_txdesc_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_from_head = 1'b0;
    logic [31:0] head_ptr = '0;
    logic        compat = 1'b0;
    logic [11:0] mac_status = '0;
    logic        mrd_req, mwr_req, frag_req;
    logic [31:0] mrd_addr, mwr_addr, mwr_data, frag_addr;
    logic        mrd_ack = 1'b0, mwr_ack = 1'b0, frag_ack = 1'b0;
    logic [31:0] mrd_data = '0;
    logic [11:0] frag_len;
    logic        frag_last, frag_nocrc, desc_irq, busy, err;

    logic [31:0] mem [64];
    logic [31:0] fl_addr [8];
    logic [11:0] fl_len  [8];
    logic        fl_last [8];
    logic        fl_ncrc [8];
    int          nfrag = 0;
    int          nirq  = 0;
    int          total = 0;
    int          bad   = 0;
    int          cyc   = 0;
    bit          done  = 0;

    always #2 clk = ~clk;

    txdesc_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_from_head(start_from_head),
        .head_ptr(head_ptr), .compat(compat), .mac_status(mac_status),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
        .frag_req(frag_req), .frag_addr(frag_addr), .frag_len(frag_len),
        .frag_last(frag_last), .frag_nocrc(frag_nocrc), .frag_ack(frag_ack),
        .desc_irq(desc_irq), .busy(busy), .err(err)
    );

    // behavioural memory, fragment sink and interrupt counter
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (desc_irq) nirq++;
            if (mrd_ack) mrd_ack = 1'b0;
            else if (mrd_req) begin
                mrd_data = mem[mrd_addr[7:2]];
                mrd_ack  = 1'b1;
            end
            if (mwr_ack) mwr_ack = 1'b0;
            else if (mwr_req) begin
                mem[mwr_addr[7:2]] = mwr_data;
                mwr_ack = 1'b1;
            end
            if (frag_ack) frag_ack = 1'b0;
            else if (frag_req) begin
                if (nfrag < 8) begin
                    fl_addr[nfrag] = frag_addr;
                    fl_len[nfrag]  = frag_len;
                    fl_last[nfrag] = frag_last;
                    fl_ncrc[nfrag] = frag_nocrc;
                end
                nfrag++;
                frag_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chkeq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic walk(input bit from_head, input logic [31:0] head);
        @(negedge clk);
        start_from_head = from_head;
        head_ptr = head;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chkeq("R1 busy", {31'd0, busy}, 32'd0);
        chkeq("R1 err", {31'd0, err}, 32'd0);
        chkeq("R1 reqs", {29'd0, mrd_req, mwr_req, frag_req}, 32'd0);
        chkeq("R1 irq", {31'd0, desc_irq}, 32'd0);
    endtask

    task automatic t_single;
        mem[0] = 32'h20; mem[1] = 32'hA000_0064; mem[2] = 32'h1003;
        mem[8] = 32'h0;  mem[9] = 32'h0;
        mac_status = 12'hABC;
        walk(1'b1, 32'h0);
        chkeq("R2 R3 stopped", {31'd0, busy}, 32'd0);
        chkeq("R4 frag count", nfrag, 1);
        chkeq("R4 frag addr", fl_addr[0], 32'h1003);
        chkeq("R4 frag len", {20'd0, fl_len[0]}, 32'd100);
        chkeq("R5 last", {31'd0, fl_last[0]}, 32'd1);
        chkeq("R8 nocrc clear", {31'd0, fl_ncrc[0]}, 32'd0);
        chkeq("R6 final wb", mem[1], 32'h2ABC_0064);
        chkeq("R7 irq count", nirq, 1);
        chkeq("R3 unowned untouched", mem[9], 32'h0);
    endtask

    task automatic t_resume_chain;
        mem[8]  = 32'h40; mem[9]  = 32'hD000_0008; mem[10] = 32'h500;
        mem[16] = 32'h60; mem[17] = 32'h9000_0000; mem[18] = 32'h600;
        mem[24] = 32'h0;  mem[25] = 32'h0;
        mac_status = 12'h123;
        walk(1'b0, 32'hFC);
        chkeq("R2 resume frag count", nfrag, 2);
        chkeq("R2 resume addr", fl_addr[1], 32'h500);
        chkeq("R5 more gives last=0", {31'd0, fl_last[1]}, 32'd0);
        chkeq("R8 nocrc masked", {31'd0, fl_ncrc[1]}, 32'd0);
        chkeq("R6 nonfinal wb", mem[9], 32'h5000_0008);
        chkeq("R4 R6 zero-len final wb", mem[17], 32'h1123_0000);
        chkeq("R7 no irq", nirq, 1);
    endtask

    task automatic t_compat;
        mem[24] = 32'h80; mem[25] = 32'h9000_0010; mem[26] = 32'hDEAD; mem[27] = 32'h2000;
        mem[32] = 32'h0;  mem[33] = 32'h0;
        mac_status = 12'h0F0;
        compat = 1'b1;
        walk(1'b0, 32'h0);
        compat = 1'b0;
        chkeq("R9 frag count", nfrag, 3);
        chkeq("R9 compat addr", fl_addr[2], 32'h2000);
        chkeq("R8 nocrc final", {31'd0, fl_ncrc[2]}, 32'd1);
        chkeq("R6 compat wb", mem[25], 32'h10F0_0010);
    endtask

    task automatic t_badlink;
        mem[32] = 32'h92; mem[33] = 32'hA000_0004; mem[34] = 32'h3000;
        walk(1'b0, 32'h0);
        chkeq("R10 err set", {31'd0, err}, 32'd1);
        chkeq("R10 stopped", {31'd0, busy}, 32'd0);
        chkeq("R10 no frag", nfrag, 3);
        chkeq("R10 no wb", mem[33], 32'hA000_0004);
        chkeq("R10 no irq", nirq, 1);
        mem[48] = 32'hE0; mem[49] = 32'h8000_0004; mem[50] = 32'h7001;
        mem[56] = 32'h0;  mem[57] = 32'h0;
        walk(1'b1, 32'hC0);
        chkeq("R10 err cleared", {31'd0, err}, 32'd0);
        chkeq("R2 head reload", fl_addr[3], 32'h7001);
        chkeq("R6 recovery wb", mem[49], 32'h00F0_0004);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_resume_chain();
        t_compat();
        t_badlink();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule